// File: doc/BRIEF.md
# Byte-Parallel BCH Parity Encoder

This block computes the check bits of a shortened binary BCH code over GF(2^13) that corrects up to 15 bit errors. It is placed in the write path of a flash page. Message bytes stream in at one byte per clock, and at the end of the block the 195-bit parity comes out so it can be stored next to the data. The parity is the remainder when the message polynomial, shifted up by 195 places, is divided by the code's generator polynomial. The stored codeword is the message followed by that remainder.

The one-bit-per-clock division shift register is unrolled eight times. A whole byte is absorbed in every clock, so a 512-byte page costs 512 beats rather than 4096. The generator polynomial is not written out as a table. It is derived at elaboration from the field's primitive polynomial, as the product of the minimal polynomials of alpha^1, alpha^3, up to alpha^29.

A block is opened with `start`, fed with `din`/`din_valid`, and closed by raising `din_last` on its final beat. `parity_valid` pulses on the following cycle, and `parity` then holds the result until the next block touches it.

Top module: `bch_par_enc`

## Requirements
- R1: The field is GF(2^13) built from x^13+x^4+x^3+x+1, with alpha = x. The generator g(x) is the product of the minimal polynomials of alpha^i for odd i from 1 to 29, and has degree 195. `parity` equals m(x)*x^195 mod g(x). Bit k of `parity` is the coefficient of x^k.
- R2: The codeword is the message bits followed by `parity[194]` down to `parity[0]`, with the first bit as the highest-degree coefficient. Evaluated at alpha^j, it is zero for every j from 1 to 30, so up to 15 bit errors can be corrected.
- R3: Each beat carries eight message bits, with `din[7]` sent first. One beat is absorbed in every clock in which `din_valid` is high, with no stall between beats.
- R4: `parity_valid` is high for exactly one cycle: the cycle after a beat with `din_valid` and `din_last` both high. At all other times it is low.
- R5: `start` clears the remainder. If `start` comes with no beat, `parity` reads zero on the next cycle. If `start` comes together with a beat, that beat is the first beat of a new block.
- R6: In a cycle with neither `start` nor `din_valid`, `parity` keeps its value.
- R7: After reset, `parity` is zero and `parity_valid` is low.
- R8: A message of all-zero bytes gives an all-zero parity.
- R9: `din` is ignored while `din_valid` is low, so idle cycles between beats do not change the result.
- R10: The block length is set only by where `din_last` falls. A 512-byte block gives a 4291-bit codeword, and shorter blocks give the parity of their own length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the remainder; opens a new block |
| din | input | 8 | Message byte, most significant bit first |
| din_valid | input | 1 | `din` carries a beat this cycle |
| din_last | input | 1 | This beat closes the block (only meaningful with `din_valid`) |
| parity | output | 195 | Current remainder; the final parity after the last beat |
| parity_valid | output | 1 | One-cycle pulse: `parity` is final |

## Verification
The properties take it for granted that `din_last` is raised only together with `din_valid`, and that a new block is always opened by `start` before its first beat or on that beat. They also assume that an all-zero byte leaves a zero remainder at zero. The stimulus drives every input on the falling clock edge. It raises `din_last` only on a valid beat, and it fills idle cycles with random `din` so that any leak of unqualified data shows up in the parity. The back-to-back case starts the next block on the beat straight after a last beat, which is the only overlap the interface allows.

// File: rtl/bch_par_enc.sv
module bch_par_enc #(
  parameter int M = 13,
  parameter int T = 15,
  parameter int W = 8,
  parameter logic [M:0] PRIM = 14'h201B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      din,
  input  logic              din_valid,
  input  logic              din_last,
  output logic [M*T-1:0]    parity,
  output logic              parity_valid
);
  localparam int PAR = M * T;

  function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ (r[M-1] ? PRIM[M-1:0] : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [PAR:0] gen_poly();
    logic [PAR:0] g, prod;
    logic [M:0][M-1:0] mp;
    logic [M-1:0] a, x1;
    x1 = '0; x1[1] = 1'b1;
    g = '0; g[0] = 1'b1;
    for (int i = 1; i < 2 * T; i += 2) begin
      a = '0; a[0] = 1'b1;
      for (int k = 0; k < i; k++) a = gf_mul(a, x1);
      mp = '0; mp[0][0] = 1'b1;
      for (int j = 0; j < M; j++) begin
        for (int k = M; k > 0; k--) mp[k] = mp[k-1] ^ gf_mul(a, mp[k]);
        mp[0] = gf_mul(a, mp[0]);
        a = gf_mul(a, a);
      end
      prod = '0;
      for (int k = 0; k <= M; k++) if (mp[k][0]) prod = prod ^ (g << k);
      g = prod;
    end
    return g;
  endfunction

  localparam logic [PAR:0]   GEN  = gen_poly();
  localparam logic [PAR-1:0] TAPS = GEN[PAR-1:0];

  logic [PAR-1:0] rem_q, rem_d, seed;
  logic           done_q;

  assign seed = start ? '0 : rem_q;

  always_comb begin
    logic fb;
    rem_d = seed;
    for (int i = W - 1; i >= 0; i--) begin
      fb    = rem_d[PAR-1] ^ din[i];
      rem_d = {rem_d[PAR-2:0], 1'b0} ^ ({PAR{fb}} & TAPS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= din_valid & din_last;
      if (din_valid)  rem_q <= rem_d;
      else if (start) rem_q <= '0;
    end
  end

  assign parity       = rem_q;
  assign parity_valid = done_q;
endmodule

// File: rtl/bch_par_enc_chk.sv
module bch_par_enc_chk #(
  parameter int W   = 8,
  parameter int PAR = 195
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   din,
  input logic           din_valid,
  input logic           din_last,
  input logic [PAR-1:0] parity,
  input logic           parity_valid
);
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid && din_last |=> parity_valid);

  a_r4_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(din_valid && din_last) |=> !parity_valid);

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start && !din_valid |=> parity == '0);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !din_valid |=> $stable(parity));

  a_r8_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid && !start && din == '0 && parity == '0 |=> parity == '0);
endmodule

bind bch_par_enc bch_par_enc_chk #(.W(W), .PAR(PAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .din(din), .din_valid(din_valid),
  .din_last(din_last), .parity(parity), .parity_valid(parity_valid)
);

// File: tb/bch_par_enc_tb.sv
module bch_par_enc_tb;
  localparam int M   = 13;
  localparam int PAR = 195;
  localparam int N   = 512;
  localparam logic [M:0] PRIM = 14'h201B;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [7:0]     din = '0;
  logic           din_valid = 1'b0;
  logic           din_last = 1'b0;
  logic [PAR-1:0] parity;
  logic           parity_valid;

  int n_chk = 0;
  int n_bad = 0;
  byte unsigned msg [0:1023];
  logic [PAR:0] gbin;

  bch_par_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .din_valid(din_valid),
    .din_last(din_last), .parity(parity), .parity_valid(parity_valid)
  );

  always #4 clk = ~clk;

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc, sh;
    acc = '0; sh = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[M-2:0], 1'b0} ^ (sh[M-1] ? PRIM[M-1:0] : '0);
    end
    return acc;
  endfunction

  function automatic logic [PAR-1:0] ref_par(input int off, input int n);
    logic [PAR-1:0] r;
    logic fb;
    r = '0;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = r[PAR-1] ^ msg[off+i][b];
        r  = {r[PAR-2:0], 1'b0};
        if (fb) r = r ^ gbin[PAR-1:0];
      end
    return r;
  endfunction

  function automatic int syn_bad(input int n, input logic [PAR-1:0] p);
    logic [M-1:0] beta, s, x1;
    int bad;
    bad = 0;
    x1 = '0; x1[1] = 1'b1;
    beta = '0; beta[0] = 1'b1;
    for (int j = 1; j <= 30; j++) begin
      beta = fmul(beta, x1);
      s = '0;
      for (int i = 0; i < n; i++)
        for (int b = 7; b >= 0; b--) s = fmul(s, beta) ^ {{(M-1){1'b0}}, msg[i][b]};
      for (int b = PAR - 1; b >= 0; b--) s = fmul(s, beta) ^ {{(M-1){1'b0}}, p[b]};
      if (s != '0) bad++;
    end
    return bad;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [PAR-1:0] act, input logic [PAR-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build_gen();
    logic [M-1:0] c [0:PAR];
    bit used [0:8190];
    logic [M-1:0] root, x1;
    int deg, e;
    bit bin_ok;
    x1 = '0; x1[1] = 1'b1;
    for (int k = 0; k < 8191; k++) used[k] = 0;
    for (int i = 1; i < 30; i += 2) begin
      e = i;
      for (int j = 0; j < M; j++) begin used[e] = 1; e = (e * 2) % 8191; end
    end
    for (int k = 0; k <= PAR; k++) c[k] = '0;
    c[0][0] = 1'b1;
    deg = 0;
    root = '0; root[0] = 1'b1;
    for (int k = 0; k < 8191; k++) begin
      if (used[k] && deg < PAR) begin
        for (int q = deg + 1; q > 0; q--) c[q] = c[q-1] ^ fmul(root, c[q]);
        c[0] = fmul(root, c[0]);
        deg++;
      end
      root = fmul(root, x1);
    end
    bin_ok = (deg == PAR);
    for (int k = 0; k <= PAR; k++) begin
      if (c[k] > 1) bin_ok = 0;
      gbin[k] = c[k][0];
    end
    chk(bin_ok && gbin[PAR], "R1 generator binary of degree 195", '0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      din = 8'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic drive(input int off, input int n, input bit start_on_first, input bit gaps);
    for (int i = 0; i < n; i++) begin
      start = start_on_first && (i == 0);
      din = msg[off+i];
      din_valid = 1'b1;
      din_last = (i == n - 1);
      @(negedge clk);
      start = 1'b0; din_valid = 1'b0; din_last = 1'b0;
      if (gaps && i < n - 1) idle($urandom_range(0, 3));
    end
  endtask

  task automatic open_block();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic close_checks(input string req, input logic [PAR-1:0] exp);
    logic [PAR-1:0] held;
    chk(parity_valid == 1'b1, "R4 done after last", {194'b0, parity_valid}, 1);
    chk(parity == exp, req, parity, exp);
    held = parity;
    idle(1);
    chk(parity_valid == 1'b0, "R4 done lasts one cycle", {194'b0, parity_valid}, 0);
    idle(3);
    chk(parity == held, "R6 R9 parity holds while idle", parity, held);
  endtask

  task automatic t_reset();
    chk(parity == '0, "R7 reset parity", parity, '0);
    chk(parity_valid == 1'b0, "R7 reset done", {194'b0, parity_valid}, 0);
  endtask

  task automatic t_zero_block();
    for (int i = 0; i < N; i++) msg[i] = 8'h00;
    open_block();
    drive(0, N, 0, 0);
    close_checks("R8 zero message zero parity", '0);
  endtask

  task automatic t_full_random();
    logic [PAR-1:0] exp;
    for (int i = 0; i < N; i++) msg[i] = 8'($urandom);
    exp = ref_par(0, N);
    open_block();
    drive(0, N, 0, 0);
    chk(syn_bad(N, parity) == 0, "R2 R10 4291-bit codeword syndromes zero", parity, exp);
    close_checks("R1 R3 512-byte parity", exp);
  endtask

  task automatic t_gapped();
    logic [PAR-1:0] exp;
    for (int i = 0; i < N; i++) msg[i] = 8'($urandom);
    exp = ref_par(0, N);
    open_block();
    drive(0, N, 0, 1);
    close_checks("R9 gaps with random din", exp);
  endtask

  task automatic t_short();
    logic [PAR-1:0] exp;
    msg[0] = 8'h80;
    exp = ref_par(0, 1);
    open_block();
    drive(0, 1, 0, 0);
    close_checks("R10 one-byte block", exp);
    chk(syn_bad(1, exp) == 0, "R2 short codeword syndromes", exp, exp);
    for (int i = 0; i < 37; i++) msg[i] = 8'($urandom);
    exp = ref_par(0, 37);
    open_block();
    drive(0, 37, 0, 0);
    close_checks("R10 37-byte block", exp);
  endtask

  task automatic t_start();
    logic [PAR-1:0] exp;
    chk(parity != '0, "R5 precondition nonzero remainder", parity, '1);
    open_block();
    chk(parity == '0, "R5 start alone clears", parity, '0);
    for (int i = 0; i < 20; i++) msg[i] = 8'($urandom);
    exp = ref_par(0, 20);
    drive(0, 20, 0, 0);
    idle(1);
    for (int i = 0; i < 20; i++) msg[i] = 8'($urandom);
    exp = ref_par(0, 20);
    drive(0, 20, 1, 0);
    close_checks("R5 start together with first beat", exp);
  endtask

  task automatic t_back_to_back();
    logic [PAR-1:0] e1, e2;
    int n1, n2;
    n1 = 64; n2 = 100;
    for (int i = 0; i < n1 + n2; i++) msg[i] = 8'($urandom);
    e1 = ref_par(0, n1);
    e2 = ref_par(n1, n2);
    for (int i = 0; i < n1 + n2; i++) begin
      start = (i == 0) || (i == n1);
      din = msg[i];
      din_valid = 1'b1;
      din_last = (i == n1 - 1) || (i == n1 + n2 - 1);
      @(negedge clk);
      start = 1'b0; din_valid = 1'b0; din_last = 1'b0;
      if (i == n1 - 1) begin
        chk(parity_valid == 1'b1, "R4 done on back-to-back", {194'b0, parity_valid}, 1);
        chk(parity == e1, "R3 first of back-to-back blocks", parity, e1);
      end
    end
    close_checks("R3 R5 second of back-to-back blocks", e2);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    build_gen();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_block();
    t_full_random();
    t_gapped();
    t_short();
    t_start();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule